// File: doc/BRIEF.md
# Modulo-PCM Pixel Decision and Reconstruction Unit

This unit carries out the per-pixel arithmetic of a modulo-PCM image decoder. Each valid input carries one 2x2 pixel group. The group's top-left sample was coded as plain PCM with its `L0` low bits removed. The other three samples were coded as modulo samples: their `L1` low bits and `M` high bits were removed. The input also holds the PCM codewords of the group's four corner neighbours in a 3x3 sample window. The top-left corner is the group's own PCM sample. The top-right corner is two columns to the right. The bottom-left corner is two rows down. The bottom-right corner is two rows down and two columns to the right.

The PCM samples are rebuilt at the middle of their quantisation interval. Each modulo sample gets a prediction from the PCM neighbours that surround it. That prediction selects one of the `2^M` aliased intervals that share the received codeword. The prediction is then clamped into the selected interval. A special parameter setting (`L0 == L1`, `M == 0`) turns the modulo path into plain midpoint dequantisation.

The unit is a three-stage pipeline that accepts one group per clock. Windowing the coded rows and serialising the decoded pixels are done outside the unit.

Top module: `mpcm_pix_dec`

## Requirements
- R1: `pix_00_o` is the top-left PCM codeword shifted left by `L0`, with bit `L0-1` set when `L0 > 0`. This is the midpoint of its interval.
- R2: The prediction for `pix_01_o` is `(tl + tr + 1) >> 1`, using the rebuilt top-left and top-right PCM pixels.
- R3: The prediction for `pix_10_o` is `(tl + bl + 1) >> 1`, using the rebuilt top-left and bottom-left PCM pixels.
- R4: The prediction for `pix_11_o` is `(tl + tr + bl + br + 2) >> 2`.
- R5: For a modulo codeword `c`, candidate `k` (0 to `2^M-1`) covers `[a_k, a_k + 2^L1 - 1]`, where `a_k = k*2^(PIX_W-M) + c*2^L1`. Its centre point is `a_k + 2^(L1-1)`, or `a_k` when `L1 = 0`. The unit picks the candidate whose centre point has the smallest absolute distance to the prediction.
- R6: When two candidates are equally distant, the one with the smaller `k` is taken.
- R7: A modulo pixel equals its prediction when the prediction lies inside the chosen interval. Otherwise it equals the lower bound when the prediction is below the interval, and the upper bound when it is above. Its bits `[PIX_W-M-1:L1]` therefore always equal the codeword.
- R8: With `L0 == L1` and `M == 0`, each modulo pixel is `a_0 + 2^(L1-1)` whatever the prediction.
- R9: `valid_o` rises exactly three rising clock edges after the edge that samples `valid_i`. Groups presented on consecutive cycles come out on consecutive cycles.
- R10: While `valid_o` is low, all four pixel outputs keep their values.
- R11: Driving `rst_ni` low clears `valid_o` and all pixel outputs at once, and discards any groups in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A group is present on the inputs |
| pcm_tl_i | input | PIX_W-L0 | PCM codeword of the group's own top-left sample |
| pcm_tr_i | input | PIX_W-L0 | PCM codeword two columns to the right |
| pcm_bl_i | input | PIX_W-L0 | PCM codeword two rows down |
| pcm_br_i | input | PIX_W-L0 | PCM codeword two rows down and two columns right |
| mod_h_i | input | PIX_W-L1-M | Modulo codeword of position (0,1) |
| mod_v_i | input | PIX_W-L1-M | Modulo codeword of position (1,0) |
| mod_d_i | input | PIX_W-L1-M | Modulo codeword of position (1,1) |
| valid_o | output | 1 | Decoded group is present on the outputs |
| pix_00_o | output | PIX_W | Decoded pixel (0,0) |
| pix_01_o | output | PIX_W | Decoded pixel (0,1) |
| pix_10_o | output | PIX_W | Decoded pixel (1,0) |
| pix_11_o | output | PIX_W | Decoded pixel (1,1) |

## Verification
In a single cycle, the last stage can be clamping one group while the middle stage makes the interval decision for the next group and the first stage rebuilds the PCM pixels of a third. The bench provokes this by streaming its whole vector table with `valid_i` held high on consecutive cycles. The table mixes in-range, below-range, above-range, aliased-upper and exact-tie predictions. The bench then judges each group's four pixels on the third edge after that group entered, so a value leaking between stages shows up as a wrong pixel in a neighbouring row. A second instance with midpoint parameters checks the dequantising variant.

// File: rtl/mpcm_pkg.sv
package mpcm_pkg;

  typedef enum logic [1:0] {
    PRED_H = 2'd0,
    PRED_V = 2'd1,
    PRED_D = 2'd2
  } pred_e;

  function automatic int half_step(input int l);
    return (l > 0) ? (1 << (l - 1)) : 0;
  endfunction

endpackage

// File: rtl/mpcm_pcm_recon.sv
module mpcm_pcm_recon #(
  parameter int PIX_W = 8,
  parameter int L0    = 1,
  localparam int PW   = PIX_W - L0
) (
  input  logic [PW-1:0]    cw_i,
  output logic [PIX_W-1:0] pix_o
);
  localparam int HALF = mpcm_pkg::half_step(L0);

  assign pix_o = (PIX_W'(cw_i) << L0) | PIX_W'(HALF);
endmodule

// File: rtl/mpcm_side_info.sv
module mpcm_side_info
  import mpcm_pkg::*;
#(
  parameter int    PIX_W = 8,
  parameter pred_e KIND  = PRED_H
) (
  input  logic [PIX_W-1:0] tl_i,
  input  logic [PIX_W-1:0] tr_i,
  input  logic [PIX_W-1:0] bl_i,
  input  logic [PIX_W-1:0] br_i,
  output logic [PIX_W-1:0] y_o
);
  logic [PIX_W:0]   sum_h, sum_v;
  logic [PIX_W+1:0] sum_d;

  always_comb begin
    sum_h = (PIX_W+1)'(tl_i) + (PIX_W+1)'(tr_i) + (PIX_W+1)'(1);
    sum_v = (PIX_W+1)'(tl_i) + (PIX_W+1)'(bl_i) + (PIX_W+1)'(1);
    sum_d = (PIX_W+2)'(tl_i) + (PIX_W+2)'(tr_i) + (PIX_W+2)'(bl_i)
          + (PIX_W+2)'(br_i) + (PIX_W+2)'(2);
    unique case (KIND)
      PRED_H:  y_o = sum_h[PIX_W:1];
      PRED_V:  y_o = sum_v[PIX_W:1];
      default: y_o = sum_d[PIX_W+1:2];
    endcase
  end
endmodule

// File: rtl/mpcm_interval_pick.sv
module mpcm_interval_pick #(
  parameter int PIX_W = 8,
  parameter int L1    = 2,
  parameter int M     = 1,
  localparam int MW   = PIX_W - L1 - M
) (
  input  logic [MW-1:0]    cw_i,
  input  logic [PIX_W-1:0] y_i,
  output logic [PIX_W-1:0] lo_o
);
  localparam int NC   = 1 << M;
  localparam int HALF = mpcm_pkg::half_step(L1);

  logic [PIX_W-1:0] cand_lo [NC];
  logic [PIX_W-1:0] cand_d  [NC];

  for (genvar k = 0; k < NC; k++) begin : g_cand
    logic [PIX_W-1:0] mid;
    assign cand_lo[k] = (PIX_W'(k) << (PIX_W - M)) | (PIX_W'(cw_i) << L1);
    assign mid        = cand_lo[k] + PIX_W'(HALF);
    assign cand_d[k]  = (y_i >= mid) ? (y_i - mid) : (mid - y_i);
  end

  // strict compare in ascending order keeps the lower candidate on a tie
  logic [PIX_W-1:0] best_d;
  always_comb begin
    lo_o   = cand_lo[0];
    best_d = cand_d[0];
    for (int k = 1; k < NC; k++) begin
      if (cand_d[k] < best_d) begin
        best_d = cand_d[k];
        lo_o   = cand_lo[k];
      end
    end
  end
endmodule

// File: rtl/mpcm_clamp.sv
module mpcm_clamp #(
  parameter int PIX_W = 8,
  parameter int L1    = 2,
  parameter bit MID   = 1'b0
) (
  input  logic [PIX_W-1:0] lo_i,
  input  logic [PIX_W-1:0] y_i,
  output logic [PIX_W-1:0] pix_o
);
  localparam int HALF = mpcm_pkg::half_step(L1);
  localparam int SPAN = (1 << L1) - 1;

  logic [PIX_W-1:0] hi, clamped;

  always_comb begin
    hi = lo_i + PIX_W'(SPAN);
    if (y_i < lo_i)      clamped = lo_i;
    else if (y_i > hi)   clamped = hi;
    else                 clamped = y_i;
    pix_o = MID ? (lo_i + PIX_W'(HALF)) : clamped;
  end
endmodule

// File: rtl/mpcm_pix_dec.sv
module mpcm_pix_dec
  import mpcm_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int L0    = 1,
  parameter int L1    = 2,
  parameter int M     = 1,
  localparam int PW   = PIX_W - L0,
  localparam int MW   = PIX_W - L1 - M
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [PW-1:0]    pcm_tl_i,
  input  logic [PW-1:0]    pcm_tr_i,
  input  logic [PW-1:0]    pcm_bl_i,
  input  logic [PW-1:0]    pcm_br_i,
  input  logic [MW-1:0]    mod_h_i,
  input  logic [MW-1:0]    mod_v_i,
  input  logic [MW-1:0]    mod_d_i,
  output logic             valid_o,
  output logic [PIX_W-1:0] pix_00_o,
  output logic [PIX_W-1:0] pix_01_o,
  output logic [PIX_W-1:0] pix_10_o,
  output logic [PIX_W-1:0] pix_11_o
);
  localparam int  NPCM = 4;
  localparam int  NMOD = 3;
  localparam bit  MID_MODE = (L0 == L1) && (M == 0);

  logic [PW-1:0]    pcm_cw  [NPCM];
  logic [MW-1:0]    mod_cw  [NMOD];

  assign pcm_cw[0] = pcm_tl_i;
  assign pcm_cw[1] = pcm_tr_i;
  assign pcm_cw[2] = pcm_bl_i;
  assign pcm_cw[3] = pcm_br_i;
  assign mod_cw[0] = mod_h_i;
  assign mod_cw[1] = mod_v_i;
  assign mod_cw[2] = mod_d_i;

  // stage 1: PCM midpoint reconstruction
  logic [PIX_W-1:0] pcm_pix [NPCM];
  logic [PIX_W-1:0] s1_pix  [NPCM];
  logic [MW-1:0]    s1_cw   [NMOD];
  logic             s1_vld;

  for (genvar i = 0; i < NPCM; i++) begin : g_recon
    mpcm_pcm_recon #(.PIX_W(PIX_W), .L0(L0)) i_recon (
      .cw_i  (pcm_cw[i]),
      .pix_o (pcm_pix[i])
    );
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      s1_pix[i] <= '0;
      else if (valid_i) s1_pix[i] <= pcm_pix[i];
    end
  end

  for (genvar j = 0; j < NMOD; j++) begin : g_s1_cw
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      s1_cw[j] <= '0;
      else if (valid_i) s1_cw[j] <= mod_cw[j];
    end
  end

  // stage 2: side information and interval decision
  logic [PIX_W-1:0] y_c   [NMOD];
  logic [PIX_W-1:0] lo_c  [NMOD];
  logic [PIX_W-1:0] s2_y  [NMOD];
  logic [PIX_W-1:0] s2_lo [NMOD];
  logic [PIX_W-1:0] s2_p00;
  logic             s2_vld;

  for (genvar j = 0; j < NMOD; j++) begin : g_decide
    mpcm_side_info #(.PIX_W(PIX_W), .KIND(pred_e'(j))) i_side (
      .tl_i (s1_pix[0]),
      .tr_i (s1_pix[1]),
      .bl_i (s1_pix[2]),
      .br_i (s1_pix[3]),
      .y_o  (y_c[j])
    );
    mpcm_interval_pick #(.PIX_W(PIX_W), .L1(L1), .M(M)) i_pick (
      .cw_i (s1_cw[j]),
      .y_i  (y_c[j]),
      .lo_o (lo_c[j])
    );
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s2_y[j]  <= '0;
        s2_lo[j] <= '0;
      end else if (s1_vld) begin
        s2_y[j]  <= y_c[j];
        s2_lo[j] <= lo_c[j];
      end
    end
  end

  // stage 3: clamp into the chosen interval
  logic [PIX_W-1:0] rec_c  [NMOD];
  logic [PIX_W-1:0] s3_pix [NMOD];
  logic [PIX_W-1:0] s3_p00;
  logic             s3_vld;

  for (genvar j = 0; j < NMOD; j++) begin : g_clamp
    mpcm_clamp #(.PIX_W(PIX_W), .L1(L1), .MID(MID_MODE)) i_clamp (
      .lo_i  (s2_lo[j]),
      .y_i   (s2_y[j]),
      .pix_o (rec_c[j])
    );
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     s3_pix[j] <= '0;
      else if (s2_vld) s3_pix[j] <= rec_c[j];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld <= 1'b0;
      s2_vld <= 1'b0;
      s3_vld <= 1'b0;
      s2_p00 <= '0;
      s3_p00 <= '0;
    end else begin
      s1_vld <= valid_i;
      s2_vld <= s1_vld;
      s3_vld <= s2_vld;
      if (s1_vld) s2_p00 <= s1_pix[0];
      if (s2_vld) s3_p00 <= s2_p00;
    end
  end

  assign valid_o  = s3_vld;
  assign pix_00_o = s3_p00;
  assign pix_01_o = s3_pix[0];
  assign pix_10_o = s3_pix[1];
  assign pix_11_o = s3_pix[2];
endmodule

// File: rtl/mpcm_pix_dec_chk.sv
module mpcm_pix_dec_chk #(
  parameter int PIX_W = 8,
  parameter int L0    = 1,
  parameter int L1    = 2,
  parameter int M     = 1,
  localparam int PW   = PIX_W - L0,
  localparam int MW   = PIX_W - L1 - M
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [PW-1:0]    pcm_tl_i,
  input logic [MW-1:0]    mod_h_i,
  input logic [MW-1:0]    mod_v_i,
  input logic [MW-1:0]    mod_d_i,
  input logic             valid_o,
  input logic [PIX_W-1:0] pix_00_o,
  input logic [PIX_W-1:0] pix_01_o,
  input logic [PIX_W-1:0] pix_10_o,
  input logic [PIX_W-1:0] pix_11_o
);
  logic [2:0] vin_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vin_q <= '0;
    else         vin_q <= {vin_q[1:0], valid_i};
  end

  // R9
  valid_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == vin_q[2]);

  // R1
  pcm_midpoint_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> pix_00_o[PIX_W-1:L0] == $past(pcm_tl_i, 3));

  // R7
  h_interval_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> pix_01_o[PIX_W-M-1:L1] == $past(mod_h_i, 3));

  // R7
  v_interval_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> pix_10_o[PIX_W-M-1:L1] == $past(mod_v_i, 3));

  // R7
  d_interval_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> pix_11_o[PIX_W-M-1:L1] == $past(mod_d_i, 3));

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable({pix_00_o, pix_01_o, pix_10_o, pix_11_o}));

  if ((L0 == L1) && (M == 0) && (L1 > 0)) begin : g_mid
    // R8
    mid_recon_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> (pix_01_o[L1-1:0] == L1'(1 << (L1 - 1)))
               && (pix_11_o[L1-1:0] == L1'(1 << (L1 - 1))));
  end
endmodule

bind mpcm_pix_dec mpcm_pix_dec_chk #(
  .PIX_W (PIX_W),
  .L0    (L0),
  .L1    (L1),
  .M     (M)
) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .pcm_tl_i (pcm_tl_i),
  .mod_h_i  (mod_h_i),
  .mod_v_i  (mod_v_i),
  .mod_d_i  (mod_d_i),
  .valid_o  (valid_o),
  .pix_00_o (pix_00_o),
  .pix_01_o (pix_01_o),
  .pix_10_o (pix_10_o),
  .pix_11_o (pix_11_o)
);

// File: tb/test_mpcm_pix_dec.sv
module test_mpcm_pix_dec;
  localparam int NV = 6;
  // {tl,tr,bl,br}[7b] {h,v,d}[5b] {e00,e01,e10,e11}[8b], with L0=1 L1=2 M=1
  localparam logic [74:0] VEC [NV] = '{
    {7'd20,  7'd20,  7'd20,  7'd20,  5'd10, 5'd11, 5'd9,  8'd41,  8'd41,  8'd44,  8'd39 },
    {7'd100, 7'd110, 7'd90,  7'd120, 5'd20, 5'd15, 5'd0,  8'd201, 8'd211, 8'd191, 8'd131},
    {7'd0,   7'd1,   7'd2,   7'd0,   5'd0,  5'd0,  5'd1,  8'd1,   8'd2,   8'd3,   8'd4  },
    {7'd32,  7'd33,  7'd40,  7'd50,  5'd0,  5'd0,  5'd3,  8'd65,  8'd3,   8'd128, 8'd140},
    {7'd127, 7'd127, 7'd127, 7'd127, 5'd31, 5'd31, 5'd0,  8'd255, 8'd255, 8'd255, 8'd131},
    {7'd64,  7'd64,  7'd64,  7'd64,  5'd0,  5'd1,  5'd31, 8'd129, 8'd129, 8'd132, 8'd127}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [6:0] pcm_tl_i = '0, pcm_tr_i = '0, pcm_bl_i = '0, pcm_br_i = '0;
  logic [4:0] mod_h_i = '0, mod_v_i = '0, mod_d_i = '0;
  logic       valid_o;
  logic [7:0] pix_00_o, pix_01_o, pix_10_o, pix_11_o;

  logic       m_valid = 1'b0;
  logic [5:0] m_tl = '0, m_tr = '0, m_bl = '0, m_br = '0;
  logic [5:0] m_h = '0, m_v = '0, m_d = '0;
  logic       m_valid_o;
  logic [7:0] m_p00, m_p01, m_p10, m_p11;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  mpcm_pix_dec i_mpcm_pix_dec (
    .clk_i, .rst_ni, .valid_i,
    .pcm_tl_i, .pcm_tr_i, .pcm_bl_i, .pcm_br_i,
    .mod_h_i, .mod_v_i, .mod_d_i,
    .valid_o, .pix_00_o, .pix_01_o, .pix_10_o, .pix_11_o
  );

  mpcm_pix_dec #(.PIX_W(8), .L0(2), .L1(2), .M(0)) i_mpcm_pix_dec_mid (
    .clk_i (clk_i), .rst_ni (rst_ni), .valid_i (m_valid),
    .pcm_tl_i (m_tl), .pcm_tr_i (m_tr), .pcm_bl_i (m_bl), .pcm_br_i (m_br),
    .mod_h_i (m_h), .mod_v_i (m_v), .mod_d_i (m_d),
    .valid_o (m_valid_o), .pix_00_o (m_p00), .pix_01_o (m_p01),
    .pix_10_o (m_p10), .pix_11_o (m_p11)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [74:0] v);
    valid_i  = 1'b1;
    pcm_tl_i = v[74:68];
    pcm_tr_i = v[67:61];
    pcm_bl_i = v[60:54];
    pcm_br_i = v[53:47];
    mod_h_i  = v[46:42];
    mod_v_i  = v[41:37];
    mod_d_i  = v[36:32];
  endtask

  task automatic check_out(input logic [74:0] v, input string tag);
    chk({"R9 valid ", tag}, {7'd0, valid_o}, 8'd1);
    chk({"R1 pix00 ", tag}, pix_00_o, v[31:24]);
    chk({"R2 pix01 ", tag}, pix_01_o, v[23:16]);
    chk({"R3 pix10 ", tag}, pix_10_o, v[15:8]);
    chk({"R4 pix11 ", tag}, pix_11_o, v[7:0]);
  endtask

  task automatic run_one(input logic [74:0] v, input string tag);
    @(negedge clk_i); drive(v);
    @(negedge clk_i); valid_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i); check_out(v, tag);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R11 reset state
    #5;
    chk("R11 reset valid", {7'd0, valid_o}, 8'd0);
    chk("R11 reset pix00", pix_00_o, 8'd0);
    chk("R11 reset pix11", pix_11_o, 8'd0);
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;

    // back-to-back stream: R9 throughput, R1..R7 per row
    for (int t = 0; t < NV + 3; t++) begin
      @(negedge clk_i);
      if (t == 1 || t == 2) chk("R9 early valid", {7'd0, valid_o}, 8'd0);
      if (t >= 3) check_out(VEC[t-3], $sformatf("row %0d", t - 3));
      if (t < NV) drive(VEC[t]);
      else valid_i = 1'b0;
    end

    // R10 outputs hold with idle input and changing codewords
    pcm_tl_i = 7'd5; mod_h_i = 5'd7; mod_d_i = 5'd2;
    for (int t = 0; t < 4; t++) begin
      @(negedge clk_i);
      chk("R10 idle valid", {7'd0, valid_o}, 8'd0);
      chk("R10 hold pix00", pix_00_o, 8'd129);
      chk("R10 hold pix01", pix_01_o, 8'd129);
      chk("R10 hold pix11", pix_11_o, 8'd127);
    end

    // directed corner cases
    run_one(VEC[3], "R6 tie to lower interval");
    chk("R6 tie pick", pix_01_o, 8'd3);
    run_one(VEC[0], "R7 clamp above and below");
    chk("R7 clamp low bound", pix_10_o, 8'd44);
    chk("R7 clamp high bound", pix_11_o, 8'd39);
    run_one(VEC[1], "R5 upper alias chosen");
    chk("R5 upper alias", pix_01_o, 8'd211);

    // R8 midpoint variant: pcm cw 10 -> 42, mod cw c -> 4c+2
    @(negedge clk_i);
    m_valid = 1'b1; m_tl = 6'd10; m_tr = 6'd10; m_bl = 6'd10; m_br = 6'd10;
    m_h = 6'd0; m_v = 6'd63; m_d = 6'd10;
    @(negedge clk_i); m_valid = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R8 mid valid", {7'd0, m_valid_o}, 8'd1);
    chk("R8 mid pix00", m_p00, 8'd42);
    chk("R8 mid pix01", m_p01, 8'd2);
    chk("R8 mid pix10", m_p10, 8'd254);
    chk("R8 mid pix11", m_p11, 8'd42);

    // R11 reset while a group is in flight
    @(negedge clk_i); drive(VEC[4]);
    @(negedge clk_i); valid_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R11 async valid", {7'd0, valid_o}, 8'd0);
    chk("R11 async pix01", pix_01_o, 8'd0);
    @(negedge clk_i); @(negedge clk_i);
    chk("R11 flight dropped", {7'd0, valid_o}, 8'd0);
    chk("R11 flight pix10", pix_10_o, 8'd0);
    rst_ni = 1'b1;
    @(negedge clk_i); @(negedge clk_i); @(negedge clk_i);
    chk("R11 stays idle", {7'd0, valid_o}, 8'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule